// File: doc/BRIEF.md
# Secondary Pairset Detection Sequencer

This block decides when detection may begin on the secondary pairset of a four-pair power-sourcing port. A two-bit mode select, together with a flag giving the signature type of the attached device, puts the port into one of two kinds of operation. In parallel operation the secondary side waits only for the primary side to finish its detection. In staggered operation the secondary side parks in an idle state and does not start until power has been applied on the primary pairset.

The sequencer reads primary-side status (power applied, detection done, detection failed, detection timer expired) and the done/valid result of a secondary detection engine. It sends the engine a one-cycle request pulse and shows its state on a three-bit output. A primary failure or timer expiry never leaves the machine stuck in its entry state. An invalid secondary result does not start a new attempt until primary power has been removed. The request and result lines are single-cycle strobes with no back-pressure, so there is no valid/ready pairing. All transitions are registered. Reset is synchronous and active high.

Top module: `sec_det_sequencer`

## Requirements
- R1: Reset, or a restart pulse, sends the state to ENTRY in the next cycle, clears the hold-reason bits and keeps the request low. Restart takes priority over every other input.
- R2: The state output uses these codes: ENTRY=0, IDLE=1, START=2, DETECT=3, DONE=4. Operation is parallel only when the mode is 0 or 2 and the device is dual-signature (single_sig_i low). Every other combination is staggered.
- R3: In staggered operation, ENTRY moves to IDLE after one cycle. IDLE moves to START only while pri_pwr_i is high.
- R4: In parallel operation, ENTRY stays put until pri_det_done_i is high and then moves straight to START, whatever the power input shows.
- R5: In ENTRY, a high pri_det_fail_i or pri_tdet_exp_i moves the state to IDLE in the next cycle. This takes priority over primary done in every mode. While either input is high, IDLE does not move to START.
- R6: START lasts one cycle and then moves to DETECT. sec_det_req_o is high in exactly the cycles spent in START.
- R7: DETECT waits for sec_det_done_i. If sec_det_valid_i is high with it, the state moves to DONE; if low, it moves to IDLE.
- R8: After an invalid secondary result, IDLE does not move to START again until pri_pwr_i has been low for at least one cycle, or until a restart.
- R9: DONE holds until a restart, or until a power drop in staggered operation.
- R10: In staggered operation, pri_pwr_i low while the state is START, DETECT or DONE forces IDLE in the next cycle.
- R11: hold_reason_o bit 0 records a primary failure and bit 1 a timer expiry, each seen while the state is ENTRY or IDLE. The bits stay set until reset or restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Port restart pulse |
| seq_mode_i | input | 2 | Sequence mode select |
| single_sig_i | input | 1 | Device has a single signature |
| pri_pwr_i | input | 1 | Primary pairset power applied |
| pri_det_done_i | input | 1 | Primary detection finished |
| pri_det_fail_i | input | 1 | Primary detection failed |
| pri_tdet_exp_i | input | 1 | Primary detection timer expired |
| sec_det_done_i | input | 1 | Secondary detection result strobe |
| sec_det_valid_i | input | 1 | Secondary result is a valid signature |
| sec_det_req_o | output | 1 | One-cycle request to start secondary detection |
| state_o | output | 3 | Current state code |
| hold_reason_o | output | 2 | Latched reasons for escaping to IDLE |

## Verification
Directed sequences cover each kind of operation separately. A staggered run with power withheld shows that gating on primary power works, because the parallel path would have started. A parallel run with power low shows that the path gated on primary done is not gated on power. Failure and timer escapes are issued while primary done is also high, which exposes the priority order in ENTRY. A run with repeated invalid results under steady power separates one attempt per power-up from endless retrying. Random mixes of mode, signature type, strobes, power and restarts then exercise the priorities between power drop, result and restart.

// File: rtl/sec_det_pkg.sv
package sec_det_pkg;
  typedef enum logic [2:0] {
    ST_ENTRY  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_START  = 3'd2,
    ST_DETECT = 3'd3,
    ST_DONE   = 3'd4
  } sec_state_e;
  localparam int REASON_W = 2;
endpackage

// File: rtl/sec_mode_decode.sv
module sec_mode_decode #(
  parameter int MODE_W = 2,
  parameter logic [(1<<MODE_W)-1:0] PAR_MODES = 4'b0101
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic              single_sig_i,
  output logic              staggered_o
);
  // Parallel only for modes flagged in PAR_MODES with a dual-signature device (R2)
  always_comb staggered_o = single_sig_i | ~PAR_MODES[mode_i];
endmodule

// File: rtl/sec_hold_status.sv
module sec_hold_status
  import sec_det_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                restart_i,
  input  logic                capture_i,
  input  logic                fail_i,
  input  logic                tmr_i,
  output logic [REASON_W-1:0] reason_o
);
  always_ff @(posedge clk) begin
    if (rst || restart_i) reason_o <= '0;
    else if (capture_i)   reason_o <= reason_o | {tmr_i, fail_i};
  end

  AST_REASON_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!restart_i && reason_o[0]) |=> reason_o[0]); // R11
endmodule

// File: rtl/sec_seq_fsm.sv
module sec_seq_fsm
  import sec_det_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart_i,
  input  logic       staggered_i,
  input  logic       pri_pwr_i,
  input  logic       pri_done_i,
  input  logic       pri_fail_i,
  input  logic       pri_tmr_i,
  input  logic       sec_done_i,
  input  logic       sec_valid_i,
  output sec_state_e st_o,
  output logic       req_o,
  output logic       capture_o
);
  sec_state_e st, nxt;
  logic       blocked;
  logic       pwr_drop, escape;

  always_comb begin
    pwr_drop = staggered_i & ~pri_pwr_i;
    escape   = pri_fail_i | pri_tmr_i;
    nxt      = st;
    if (restart_i) nxt = ST_ENTRY;
    else begin
      unique case (st)
        ST_ENTRY:  if (escape || staggered_i) nxt = ST_IDLE;
                   else if (pri_done_i)       nxt = ST_START;
        ST_IDLE:   if (pri_pwr_i && !blocked && !escape) nxt = ST_START;
        ST_START:  nxt = pwr_drop ? ST_IDLE : ST_DETECT;
        ST_DETECT: if (pwr_drop)        nxt = ST_IDLE;
                   else if (sec_done_i) nxt = sec_valid_i ? ST_DONE : ST_IDLE;
        ST_DONE:   if (pwr_drop) nxt = ST_IDLE;
        default:   nxt = ST_ENTRY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_ENTRY;
    else     st <= nxt;
  end

  // One detection attempt per application of primary power (R8)
  always_ff @(posedge clk) begin
    if (rst || restart_i || !pri_pwr_i) blocked <= 1'b0;
    else if (st == ST_DETECT && sec_done_i && !sec_valid_i) blocked <= 1'b1;
  end

  assign st_o      = st;
  assign req_o     = (st == ST_START);
  assign capture_o = (st == ST_ENTRY) || (st == ST_IDLE);

  AST_RESET_ENTRY: assert property (@(posedge clk)
    rst |=> st == ST_ENTRY); // R1
  AST_STAG_GATE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !pri_pwr_i && !restart_i) |=> st == ST_IDLE); // R3
  AST_ENTRY_ESCAPE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ENTRY && !restart_i && (pri_fail_i || pri_tmr_i)) |=> st == ST_IDLE); // R5
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o); // R6
  AST_PWR_DROP: assert property (@(posedge clk) disable iff (rst)
    (staggered_i && !pri_pwr_i && !restart_i &&
     (st == ST_START || st == ST_DETECT || st == ST_DONE)) |=> st == ST_IDLE); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE && !restart_i && !(staggered_i && !pri_pwr_i)) |=> st == ST_DONE); // R9
endmodule

// File: rtl/sec_det_sequencer.sv
module sec_det_sequencer
  import sec_det_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic [MODE_W-1:0] seq_mode_i,
  input  logic              single_sig_i,
  input  logic              pri_pwr_i,
  input  logic              pri_det_done_i,
  input  logic              pri_det_fail_i,
  input  logic              pri_tdet_exp_i,
  input  logic              sec_det_done_i,
  input  logic              sec_det_valid_i,
  output logic              sec_det_req_o,
  output logic [2:0]        state_o,
  output logic [REASON_W-1:0] hold_reason_o
);
  localparam int NMODES = 1 << MODE_W;
  localparam logic [NMODES-1:0] PAR_MASK = NMODES'(5);

  logic       staggered, capture;
  sec_state_e st;

  sec_mode_decode #(.MODE_W(MODE_W), .PAR_MODES(PAR_MASK)) u_mode (
    .mode_i(seq_mode_i), .single_sig_i(single_sig_i), .staggered_o(staggered));

  sec_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .restart_i(restart_i), .staggered_i(staggered),
    .pri_pwr_i(pri_pwr_i), .pri_done_i(pri_det_done_i), .pri_fail_i(pri_det_fail_i),
    .pri_tmr_i(pri_tdet_exp_i), .sec_done_i(sec_det_done_i), .sec_valid_i(sec_det_valid_i),
    .st_o(st), .req_o(sec_det_req_o), .capture_o(capture));

  sec_hold_status u_hold (
    .clk(clk), .rst(rst), .restart_i(restart_i), .capture_i(capture),
    .fail_i(pri_det_fail_i), .tmr_i(pri_tdet_exp_i), .reason_o(hold_reason_o));

  assign state_o = st;
endmodule

// File: tb/tb_sec_det_sequencer.sv
module tb_sec_det_sequencer;
  logic clk = 1'b0;
  logic rst, restart, single_sig, pwr, pdone, pfail, ptmr, sdone, svalid;
  logic [1:0] mode;
  logic req;
  logic [2:0] state;
  logic [1:0] reason;
  int checks = 0, errors = 0;
  int m_st = 0;
  logic [1:0] m_rsn = 2'b00;
  logic m_blk = 1'b0;

  always #4 clk = ~clk;

  sec_det_sequencer dut (
    .clk(clk), .rst(rst), .restart_i(restart), .seq_mode_i(mode), .single_sig_i(single_sig),
    .pri_pwr_i(pwr), .pri_det_done_i(pdone), .pri_det_fail_i(pfail), .pri_tdet_exp_i(ptmr),
    .sec_det_done_i(sdone), .sec_det_valid_i(svalid), .sec_det_req_o(req),
    .state_o(state), .hold_reason_o(reason));

  function automatic logic is_stag(logic [1:0] md, logic ss);
    return ss || !(md == 2'd0 || md == 2'd2); // R2
  endfunction

  // Reference step following the requirements (R1..R11)
  task automatic model_step();
    int n;
    logic stg, drop, esc;
    stg = is_stag(mode, single_sig); drop = stg && !pwr; esc = pfail || ptmr;
    n = m_st;
    if (rst || restart) n = 0;
    else case (m_st)
      0: if (esc || stg) n = 1; else if (pdone) n = 2;
      1: if (pwr && !m_blk && !esc) n = 2;
      2: n = drop ? 1 : 3;
      3: if (drop) n = 1; else if (sdone) n = svalid ? 4 : 1;
      4: if (drop) n = 1;
      default: n = 0;
    endcase
    if (rst || restart) m_rsn = 2'b00;
    else if (m_st <= 1) m_rsn = m_rsn | {ptmr, pfail};
    if (rst || restart || !pwr) m_blk = 1'b0;
    else if (m_st == 3 && sdone && !svalid) m_blk = 1'b1;
    m_st = n;
  endtask

  task automatic check(string tag);
    logic exp_req;
    exp_req = (m_st == 2);
    checks++;
    if (state !== 3'(m_st) || req !== exp_req || reason !== m_rsn) begin
      errors++;
      $display("FAIL %s: state=%0d req=%0b reason=%b expected state=%0d req=%0b reason=%b",
               tag, state, req, reason, m_st, exp_req, m_rsn);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk); model_step();
    @(negedge clk); check(tag);
  endtask

  task automatic idle_in();
    restart = 0; pwr = 0; pdone = 0; pfail = 0; ptmr = 0; sdone = 0; svalid = 0;
  endtask

  task automatic do_restart(logic [1:0] md, logic ss);
    idle_in(); mode = md; single_sig = ss; restart = 1; cyc("R1"); restart = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_in(); mode = 2'd3; single_sig = 0; rst = 1;
    @(negedge clk); cyc("R1"); cyc("R1");
    rst = 0;
    // R3 staggered, mode 3: ENTRY->IDLE, no start without power
    cyc("R3"); cyc("R3"); cyc("R3");
    pwr = 1; cyc("R3"); cyc("R6"); cyc("R6");
    sdone = 1; svalid = 1; cyc("R7"); sdone = 0; svalid = 0;
    cyc("R9"); cyc("R9");
    pwr = 0; cyc("R10"); cyc("R10");
    // R4 parallel mode 0 dual: waits for primary done, no power needed
    do_restart(2'd0, 1'b0);
    cyc("R4"); cyc("R4"); pdone = 1; cyc("R4"); pdone = 0; cyc("R6");
    sdone = 1; svalid = 0; cyc("R7"); sdone = 0; cyc("R7");
    // R5 escape: fail with done in mode 2 dual
    do_restart(2'd2, 1'b0);
    pdone = 1; pfail = 1; cyc("R5"); pdone = 0; pfail = 0; cyc("R11");
    pwr = 1; ptmr = 1; cyc("R5"); ptmr = 0; cyc("R11"); cyc("R11");
    // R8 anti-cycling: invalid under steady power
    do_restart(2'd1, 1'b0);
    pwr = 1; cyc("R8"); cyc("R8"); cyc("R8");
    sdone = 1; svalid = 0; cyc("R8"); sdone = 0;
    cyc("R8"); cyc("R8"); cyc("R8");
    pwr = 0; cyc("R8"); pwr = 1; cyc("R8"); cyc("R8");
    // R2 single-signature in mode 0 is staggered
    do_restart(2'd0, 1'b1);
    pdone = 1; cyc("R2"); cyc("R2"); pdone = 0;
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) begin mode = 2'($urandom); single_sig = 1'($urandom); end
      restart = ($urandom_range(0, 59) == 0);
      if ($urandom_range(0, 9) == 0) pwr = ~pwr;
      pdone  = ($urandom_range(0, 5) == 0);
      pfail  = ($urandom_range(0, 29) == 0);
      ptmr   = ($urandom_range(0, 29) == 0);
      sdone  = ($urandom_range(0, 3) == 0);
      svalid = 1'($urandom);
      cyc("R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule